// File: doc/BRIEF.md
# Power Mode and Clock Divider Controller

This block decides which operating power mode a small processor subsystem is in. It also sets the ratio at which the system clock is divided. Software programs a three-bit clock-select code and issues a sleep strobe. The standby-select bit decides whether that strobe leads to light sleep, where only the CPU clock stops, or to software standby, where the peripheral clocks stop as well.

Each low-power mode has its own wake source. While the block sleeps it keeps the divider setting, and on wake it returns to the same divided or undivided operation. A request to return to full speed takes effect only at the end of the current bus cycle. The reset pin, a watchdog overflow and the hardware standby pin override everything else. After a reset of sufficient length, a one-cycle pulse tells the CPU to start its reset exception.

A one-bit enable, `div_tick`, carries the chosen ratio to the clocked logic downstream.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: When running, a write of clock-select code 001 sets `div_ratio` to 1 (divide by 2), and a write of code 010 sets it to 2 (divide by 4), from the next cycle. `mode` then reads 1 (divided). With `div_ratio` at 0, `mode` reads 0 (full speed).
- R2: A write of code 000 while divided does not change the ratio until a cycle with `bus_end` high. If `bus_end` is high in the write cycle, the ratio goes to 0 on the next cycle.
- R3: Codes 011 through 111 are ignored, and the current ratio is kept.
- R4: A sleep strobe with `stby_sel`=0 enters sleep (`mode`=2). In sleep `cpu_clk_stop`=1 and `per_clk_stop`=0. A return to full speed that is still waiting for `bus_end` completes on entry.
- R5: A sleep strobe with `stby_sel`=1 enters software standby (`mode`=3), where both clock-stop outputs are 1.
- R6: Sleep ends on NMI, or on an interrupt whose request and enable bits are both 1 while `cpu_mask` is 0. A disabled interrupt does not end sleep. With `cpu_mask`=1, only NMI ends sleep.
- R7: Software standby ends only on `ext_irq`. NMI and ordinary interrupts leave it in standby.
- R8: On wake from either low-power mode, the ratio and mode in force before entry are restored.
- R9: `res_n` low or `wdt_ovf` high enters the reset state (`mode`=5) with ratio 0 and `cpu_clk_stop`=1. The reset state is left for full speed on the first cycle with `res_n` high and no overflow.
- R10: `stby_n` low enters hardware standby (`mode`=4) from any state, with ratio 0 and both clock stops at 1. This takes priority over reset. Hardware standby is left only through the reset state.
- R11: `rst_exc_start` pulses high for one cycle, in the cycle the block enters full speed, only if `res_n` was low for at least MIN_RES_CYC consecutive cycles. A shorter reset, or a watchdog reset, gives no pulse.
- R12: `div_tick` is high every cycle at ratio 0, every second cycle at ratio 1, and every fourth cycle at ratio 2.
- R13: Clock-select writes are ignored outside the running modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Clock-select write strobe |
| sel_code | input | 3 | Clock-select code |
| stby_sel | input | 1 | Standby-select bit: 0 sleep, 1 software standby |
| sleep_req | input | 1 | Sleep instruction strobe |
| bus_end | input | 1 | End of the current bus cycle |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Interrupt enables |
| cpu_mask | input | 1 | CPU masks all interrupts except NMI |
| nmi | input | 1 | Non-maskable interrupt |
| ext_irq | input | 1 | External interrupt flag |
| res_n | input | 1 | Reset pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow |
| stby_n | input | 1 | Hardware standby pin, active low |
| mode | output | 3 | 0 full, 1 divided, 2 sleep, 3 sw standby, 4 hw standby, 5 reset |
| cpu_clk_stop | output | 1 | CPU clock stopped |
| per_clk_stop | output | 1 | Peripheral clocks stopped |
| div_ratio | output | 2 | 0 /1, 1 /2, 2 /4 |
| div_tick | output | 1 | Divided clock enable |
| rst_exc_start | output | 1 | Reset exception start pulse |

## Verification
The hardest case to reach is a return to full speed that is still waiting for its bus cycle to end when the sleep strobe arrives. The bench writes code 000 with `bus_end` held low, confirms that the ratio has not moved, and then issues the strobe. The restored ratio after an NMI wake shows whether the pending clear completed. The reset pulse length is probed both one cycle short and at exactly the minimum duration. Wake qualifiers are applied one at a time, so each one that should be ignored gets its own observation before the qualifier that should wake.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_SWSTB = 3'd2,
        ST_HWSTB = 3'd3,
        ST_RESET = 3'd4
    } st_t;

    typedef enum logic [2:0] {
        M_FULL  = 3'd0,
        M_DIV   = 3'd1,
        M_SLEEP = 3'd2,
        M_SWSTB = 3'd3,
        M_HWSTB = 3'd4,
        M_RESET = 3'd5
    } mode_t;

    localparam logic [1:0] RATIO_1 = 2'd0;
    localparam logic [1:0] RATIO_2 = 2'd1;
    localparam logic [1:0] RATIO_4 = 2'd2;

    typedef struct packed {
        st_t        st;
        logic [1:0] ratio;
        logic       pend;
    } ctl_t;

    function automatic mode_t mode_of(st_t s, logic [1:0] r);
        case (s)
            ST_RUN:   return (r != RATIO_1) ? M_DIV : M_FULL;
            ST_SLEEP: return M_SLEEP;
            ST_SWSTB: return M_SWSTB;
            ST_HWSTB: return M_HWSTB;
            default:  return M_RESET;
        endcase
    endfunction

endpackage

// File: rtl/pcm_wake_qual.sv
module pcm_wake_qual #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             cpu_mask,
    input  logic             nmi,
    input  logic             ext_irq,
    output logic             wake_sleep,
    output logic             wake_swstb
);
    logic [N_IRQ-1:0] live;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_live
        assign live[i] = irq_req[i] & irq_en[i];
    end

    assign wake_sleep = nmi | (~cpu_mask & (|live));
    assign wake_swstb = ext_irq;
endmodule

// File: rtl/pcm_rst_timer.sv
module pcm_rst_timer #(
    parameter int MIN_RES_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic res_n,
    input  logic stby_n,
    input  logic wdt_ovf,
    output logic exc_start
);
    localparam int CW = $clog2(MIN_RES_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_RES_CYC);

    logic [CW-1:0] low_cnt;
    logic          low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            low_q     <= 1'b0;
            exc_start <= 1'b0;
        end else begin
            low_q <= ~res_n;
            if (!res_n) begin
                if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
            exc_start <= res_n & low_q & stby_n & ~wdt_ovf & (low_cnt >= LIMIT);
        end
    end

    assert_exc_single_R11: assert property (@(posedge clk) disable iff (rst)
        exc_start |=> !exc_start);
endmodule

// File: rtl/pcm_div_tick.sv
module pcm_div_tick (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ratio,
    output logic       tick
);
    import pcm_pkg::*;

    logic [1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    always_comb begin
        case (ratio)
            RATIO_2: tick = (phase[0] == 1'b0);
            RATIO_4: tick = (phase == 2'd0);
            default: tick = 1'b1;
        endcase
    end

    assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (rst)
        (tick && ratio != RATIO_1 && ratio == $past(ratio)) |=> (!tick || ratio != $past(ratio)));
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl #(
    parameter int N_IRQ       = 8,
    parameter int MIN_RES_CYC = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [2:0]       sel_code,
    input  logic             stby_sel,
    input  logic             sleep_req,
    input  logic             bus_end,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             cpu_mask,
    input  logic             nmi,
    input  logic             ext_irq,
    input  logic             res_n,
    input  logic             wdt_ovf,
    input  logic             stby_n,
    output logic [2:0]       mode,
    output logic             cpu_clk_stop,
    output logic             per_clk_stop,
    output logic [1:0]       div_ratio,
    output logic             div_tick,
    output logic             rst_exc_start
);
    import pcm_pkg::*;

    ctl_t  cur, nxt;
    mode_t mode_e;
    logic  wake_sleep, wake_swstb;

    pcm_wake_qual #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .cpu_mask  (cpu_mask),
        .nmi       (nmi),
        .ext_irq   (ext_irq),
        .wake_sleep(wake_sleep),
        .wake_swstb(wake_swstb)
    );

    pcm_rst_timer #(.MIN_RES_CYC(MIN_RES_CYC)) u_rtim (
        .clk      (clk),
        .rst      (rst),
        .res_n    (res_n),
        .stby_n   (stby_n),
        .wdt_ovf  (wdt_ovf),
        .exc_start(rst_exc_start)
    );

    pcm_div_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .ratio(cur.ratio),
        .tick (div_tick)
    );

    always_comb begin
        nxt = cur;
        if (!stby_n) begin
            nxt.st    = ST_HWSTB;
            nxt.ratio = RATIO_1;
            nxt.pend  = 1'b0;
        end else if (!res_n || wdt_ovf) begin
            nxt.st    = ST_RESET;
            nxt.ratio = RATIO_1;
            nxt.pend  = 1'b0;
        end else begin
            case (cur.st)
                ST_RESET: nxt.st = ST_RUN;
                ST_HWSTB: nxt.st = ST_HWSTB;
                ST_SLEEP: if (wake_sleep) nxt.st = ST_RUN;
                ST_SWSTB: if (wake_swstb) nxt.st = ST_RUN;
                default: begin
                    if (cur.pend && bus_end) begin
                        nxt.ratio = RATIO_1;
                        nxt.pend  = 1'b0;
                    end
                    if (sel_wr) begin
                        case (sel_code)
                            3'b001: begin nxt.ratio = RATIO_2; nxt.pend = 1'b0; end
                            3'b010: begin nxt.ratio = RATIO_4; nxt.pend = 1'b0; end
                            3'b000: begin
                                if (cur.ratio != RATIO_1) begin
                                    if (bus_end) begin
                                        nxt.ratio = RATIO_1;
                                        nxt.pend  = 1'b0;
                                    end else begin
                                        nxt.pend  = 1'b1;
                                    end
                                end
                            end
                            default: ;
                        endcase
                    end
                    if (sleep_req) begin
                        nxt.st = stby_sel ? ST_SWSTB : ST_SLEEP;
                        if (nxt.pend) begin
                            nxt.ratio = RATIO_1;
                            nxt.pend  = 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st    <= ST_RUN;
            cur.ratio <= RATIO_1;
            cur.pend  <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

    assign mode_e       = mode_of(cur.st, cur.ratio);
    assign mode         = mode_e;
    assign div_ratio    = cur.ratio;
    assign cpu_clk_stop = (cur.st != ST_RUN);
    assign per_clk_stop = (cur.st == ST_SWSTB) || (cur.st == ST_HWSTB);

    assert_hwstb_entry_R10: assert property (@(posedge clk) disable iff (rst)
        !stby_n |=> (mode == 3'(M_HWSTB) && div_ratio == RATIO_1));

    assert_reset_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (stby_n && (!res_n || wdt_ovf)) |=> (mode == 3'(M_RESET) && div_ratio == RATIO_1));

    assert_sleep_clocks_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'(M_SLEEP)) |-> (cpu_clk_stop && !per_clk_stop));

    assert_reserved_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (cur.st == ST_RUN && sel_wr && sel_code >= 3'd3 && !sleep_req && !cur.pend
         && stby_n && res_n && !wdt_ovf) |=> $stable(div_ratio));

    assert_swstb_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'(M_SWSTB) && !ext_irq && stby_n && res_n && !wdt_ovf) |=> (mode == 3'(M_SWSTB)));

    assert_sleep_ratio_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (cur.st == ST_SLEEP && stby_n && res_n && !wdt_ovf) |=> $stable(div_ratio));
endmodule

// File: tb/sim_pwr_clk_ctrl.sv
module sim_pwr_clk_ctrl;
    localparam int N_IRQ = 4;
    localparam int MINR  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_wr = 0, stby_sel = 0, sleep_req = 0, bus_end = 0;
    logic [2:0] sel_code = 0;
    logic [N_IRQ-1:0] irq_req = 0, irq_en = 0;
    logic cpu_mask = 0, nmi = 0, ext_irq = 0;
    logic res_n = 1, wdt_ovf = 0, stby_n = 1;
    logic [2:0] mode;
    logic cpu_clk_stop, per_clk_stop, div_tick, rst_exc_start;
    logic [1:0] div_ratio;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [2:0] m;
        logic [1:0] r;
        logic       cs, ps, ex;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    pwr_clk_ctrl #(.N_IRQ(N_IRQ), .MIN_RES_CYC(MINR)) u0 (
        .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_code(sel_code),
        .stby_sel(stby_sel), .sleep_req(sleep_req), .bus_end(bus_end),
        .irq_req(irq_req), .irq_en(irq_en), .cpu_mask(cpu_mask), .nmi(nmi),
        .ext_irq(ext_irq), .res_n(res_n), .wdt_ovf(wdt_ovf), .stby_n(stby_n),
        .mode(mode), .cpu_clk_stop(cpu_clk_stop), .per_clk_stop(per_clk_stop),
        .div_ratio(div_ratio), .div_tick(div_tick), .rst_exc_start(rst_exc_start)
    );

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic expect_out(string tag, logic [2:0] m, logic [1:0] r,
                              logic cs, logic ps, logic ex = 1'b0);
        exp_t e;
        e.tag = tag; e.m = m; e.r = r; e.cs = cs; e.ps = ps; e.ex = ex;
        sb.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic wr(logic [2:0] c, logic be = 1'b0);
        sel_wr = 1; sel_code = c; bus_end = be;
        step();
        sel_wr = 0; bus_end = 0;
    endtask

    task automatic slp(logic s);
        sleep_req = 1; stby_sel = s;
        step();
        sleep_req = 0;
    endtask

    task automatic tick_count(string tag, int want);
        int n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (div_tick) n++;
        end
        checks++;
        if (n != want) begin
            errors++;
            $display("FAIL %s: ticks in 8 cycles actual %0d expected %0d", tag, n, want);
        end
        @(posedge clk); #2;
    endtask

    // monitor: pops expectations and compares on the falling edge
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (mode !== e.m || div_ratio !== e.r || cpu_clk_stop !== e.cs ||
                per_clk_stop !== e.ps || rst_exc_start !== e.ex) begin
                errors++;
                $display("FAIL %s: actual mode=%0d ratio=%0d cs=%b ps=%b ex=%b expected mode=%0d ratio=%0d cs=%b ps=%b ex=%b",
                         e.tag, mode, div_ratio, cpu_clk_stop, per_clk_stop, rst_exc_start,
                         e.m, e.r, e.cs, e.ps, e.ex);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2); rst = 0; step();
        expect_out("reset state", 0, 0, 0, 0);

        wr(3'b001);  expect_out("R1 code 001", 1, 1, 0, 0);
        wr(3'b010);  expect_out("R1 code 010", 1, 2, 0, 0);
        wr(3'b101);  expect_out("R3 code 101", 1, 2, 0, 0);
        wr(3'b011);  expect_out("R3 code 011", 1, 2, 0, 0);
        wr(3'b111);  expect_out("R3 code 111", 1, 2, 0, 0);

        wr(3'b000);  expect_out("R2 clear deferred", 1, 2, 0, 0);
        step();      expect_out("R2 still deferred", 1, 2, 0, 0);
        bus_end = 1; step(); bus_end = 0;
        expect_out("R2 clear at bus end", 0, 0, 0, 0);
        wr(3'b010);  wr(3'b000, 1'b1);
        expect_out("R2 same-cycle bus end", 0, 0, 0, 0);

        wr(3'b001);
        slp(0);      expect_out("R4 sleep entry", 2, 1, 1, 0);
        wr(3'b010);  expect_out("R13 write in sleep ignored", 2, 1, 1, 0);
        irq_req = 1; step(); expect_out("R6 disabled irq", 2, 1, 1, 0);
        irq_en = 1; cpu_mask = 1; step(); expect_out("R6 masked irq", 2, 1, 1, 0);
        nmi = 1; step(); nmi = 0; expect_out("R6 R8 nmi wake restores /2", 1, 1, 0, 0);
        irq_req = 0; irq_en = 0; cpu_mask = 0;

        slp(0);      expect_out("R4 sleep again", 2, 1, 1, 0);
        irq_req = 2; irq_en = 2; step(); irq_req = 0; irq_en = 0;
        expect_out("R6 enabled irq wakes", 1, 1, 0, 0);

        wr(3'b010);
        slp(1);      expect_out("R5 sw standby entry", 3, 2, 1, 1);
        nmi = 1; step(); nmi = 0; expect_out("R7 nmi ignored", 3, 2, 1, 1);
        irq_req = 1; irq_en = 1; step(); irq_req = 0; irq_en = 0;
        expect_out("R7 irq ignored", 3, 2, 1, 1);
        wr(3'b001);  expect_out("R13 write in standby ignored", 3, 2, 1, 1);
        ext_irq = 1; step(); ext_irq = 0;
        expect_out("R7 R8 ext wake restores /4", 1, 2, 0, 0);

        wr(3'b000);  expect_out("R2 pending before sleep", 1, 2, 0, 0);
        slp(0);      expect_out("R4 pending clear done on sleep", 2, 0, 1, 0);
        nmi = 1; step(); nmi = 0; expect_out("R8 wake to full", 0, 0, 0, 0);

        wr(3'b010);  tick_count("R12 ratio 4", 2);
        wr(3'b001);  tick_count("R12 ratio 2", 4);
        wr(3'b000, 1'b1); tick_count("R12 ratio 1", 8);

        wr(3'b001);
        wdt_ovf = 1; step(); wdt_ovf = 0;
        expect_out("R9 watchdog reset", 5, 0, 1, 0);
        step();      expect_out("R9 R11 leave reset, no pulse", 0, 0, 0, 0, 0);

        res_n = 0; step(MINR - 1);
        expect_out("R9 pin reset", 5, 0, 1, 0);
        res_n = 1; step();
        expect_out("R11 short reset no pulse", 0, 0, 0, 0, 0);

        res_n = 0; step(MINR); res_n = 1; step();
        expect_out("R11 pulse after full reset", 0, 0, 0, 0, 1);
        step();      expect_out("R11 pulse one cycle", 0, 0, 0, 0, 0);

        wr(3'b010);
        stby_n = 0; step(); expect_out("R10 hw standby entry", 4, 0, 1, 1);
        stby_n = 1; step(); expect_out("R10 held without reset", 4, 0, 1, 1);
        res_n = 0; step(); expect_out("R10 exit via reset", 5, 0, 1, 0);
        stby_n = 0; step(); expect_out("R10 priority over reset", 4, 0, 1, 1);
        stby_n = 1; step(); expect_out("R10 reset after release", 5, 0, 1, 0);
        res_n = 1; step(); expect_out("R9 reset to full", 0, 0, 0, 0, 0);

        step(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule